// File: doc/BRIEF.md
# Transceiver Quad Control and Status Register Bank

This block is the register-mapped front end for an array of up to sixteen serial transceiver quads, each with four lanes. A simple synchronous register bus (address, write data, write strobe, read strobe, read data, acknowledge) reaches one control register per quad. That register sets the quad's four lane enables and a 3-bit loopback mode. Through two strobe registers the bus can also fire one-cycle transmit-side and receive-side soft-reset pulses for any set of quads.

PLL status arrives one bit per quad. Transmit reset status arrives one bit per full-duplex lane, and the bench treats that lane index as equal to the quad index. Receive status arrives one bit per lane. All of these are presented as read-only words. A 64-bit lane vector occupies two consecutive addresses, with the low word at the even address.

A compile-time quad mask decides which quads get hardware. A masked-off quad has no control flops and never pulses, and its status bits read as zero.

Top module: `xcvr_regbank`

## Requirements
- R1: After reset every lane enable, every loopback field and both soft-reset pulse vectors are 0, and every control register reads 0.
- R2: A write to address q (q below N_QUADS) stores wdata[3:0] as the lane enables of quad q (output bits 4q+3..4q) and wdata[6:4] as its loopback mode (output bits 3q+2..3q). The outputs change at the write's clock edge. A read of that address returns these seven bits with all upper bits 0, and the fields hold their value until the next write to that address.
- R3: A write to address 0x10 drives tx_srst[q] high for exactly one cycle for every enabled quad q whose data bit q is 1. Reading 0x10 returns 0.
- R4: A write to address 0x11 drives rx_srst in the same way, and reading 0x11 returns 0. A write to either strobe address leaves the other pulse vector at 0.
- R5: Addresses 0x12, 0x13 and 0x14 return the per-quad PLL lock, reference-clock-lost and PLL reset-done inputs, with quad q at bit q.
- R6: Addresses 0x15 and 0x16 return the transmit reset-done and transmit reset-FSM-done inputs, with lane q at bit q.
- R7: The per-lane receive inputs are mapped as follows. Receive reset-done is at 0x18/0x19, receive reset-FSM-done at 0x1A/0x1B, byte-aligned at 0x1C/0x1D, realign at 0x1E/0x1F, disparity error at 0x20/0x21 and encode error at 0x22/0x23. Lanes 31..0 are at the even address and lanes 63..32 at the odd address, with lane n at bit n mod 32.
- R8: For a quad whose QUAD_MASK bit is 0, writes to its control register are ignored, its lane enables, loopback and pulses stay 0, and all of its status bits read 0.
- R9: Every read or write strobe is acknowledged exactly one cycle later. Reads of addresses outside the map (0x04 onward below 0x10 in a four-quad build, 0x17, and 0x24 to 0xFF) return 0.
- R10: Writes to the read-only addresses (0x12 to 0xFF) change no control output, no control register and no status read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid with ack |
| ack | output | 1 | Access acknowledge, one cycle after a strobe |
| lane_en | output | 4*N_QUADS | Lane enables, four per quad |
| loopback | output | 3*N_QUADS | Loopback mode, three bits per quad |
| tx_srst | output | N_QUADS | Transmit soft-reset pulse per quad |
| rx_srst | output | N_QUADS | Receive soft-reset pulse per quad |
| pll_lock | input | N_QUADS | PLL locked per quad |
| refclk_lost | input | N_QUADS | Reference clock lost per quad |
| pll_rst_done | input | N_QUADS | PLL reset done per quad |
| tx_rst_done | input | N_QUADS | Transmit reset done per full-duplex lane |
| tx_fsm_done | input | N_QUADS | Transmit reset FSM done per full-duplex lane |
| rx_rst_done | input | 4*N_QUADS | Receive reset done per lane |
| rx_fsm_done | input | 4*N_QUADS | Receive reset FSM done per lane |
| rx_aligned | input | 4*N_QUADS | Byte aligned per lane |
| rx_realign | input | 4*N_QUADS | Realign seen per lane |
| rx_disperr | input | 4*N_QUADS | Disparity error per lane |
| rx_encerr | input | 4*N_QUADS | Encode error per lane |

## Verification
The bench builds the block with N_QUADS = 4 and QUAD_MASK = 4'b1011, so quad 2 has no hardware while its neighbours on both sides do. In this small build all 128 values of every control field can be written to every quad, all 16 strobe patterns can be tried on each reset vector, and all 256 addresses can be read back against arithmetically computed values. These sweeps run under several status input patterns. Because only sixteen lanes exist, every odd lane-status address must read zero, which exercises the high-word path.

// File: rtl/xcvr_regbank.sv
module xcvr_regbank #(
  parameter int N_QUADS = 16,
  parameter logic [N_QUADS-1:0] QUAD_MASK = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             addr,
  input  logic [31:0]            wdata,
  input  logic                   wr,
  input  logic                   rd,
  output logic [31:0]            rdata,
  output logic                   ack,
  output logic [4*N_QUADS-1:0]   lane_en,
  output logic [3*N_QUADS-1:0]   loopback,
  output logic [N_QUADS-1:0]     tx_srst,
  output logic [N_QUADS-1:0]     rx_srst,
  input  logic [N_QUADS-1:0]     pll_lock,
  input  logic [N_QUADS-1:0]     refclk_lost,
  input  logic [N_QUADS-1:0]     pll_rst_done,
  input  logic [N_QUADS-1:0]     tx_rst_done,
  input  logic [N_QUADS-1:0]     tx_fsm_done,
  input  logic [4*N_QUADS-1:0]   rx_rst_done,
  input  logic [4*N_QUADS-1:0]   rx_fsm_done,
  input  logic [4*N_QUADS-1:0]   rx_aligned,
  input  logic [4*N_QUADS-1:0]   rx_realign,
  input  logic [4*N_QUADS-1:0]   rx_disperr,
  input  logic [4*N_QUADS-1:0]   rx_encerr
);
  localparam int LANES = 4 * N_QUADS;
  localparam logic [7:0] A_TXRST = 8'h10;
  localparam logic [7:0] A_RXRST = 8'h11;
  localparam logic [7:0] A_LANE0 = 8'h18;

  logic [LANES-1:0] lane_mask;
  logic [6:0]       ctrl_q [N_QUADS];
  logic [63:0]      lane_st [6];
  logic [31:0]      rd_mux;

  for (genvar q = 0; q < N_QUADS; q++) begin : g_quad
    assign lane_mask[4*q +: 4] = {4{QUAD_MASK[q]}};
    if (QUAD_MASK[q]) begin : g_on
      logic [3:0] en_r;
      logic [2:0] lb_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          en_r <= '0;
          lb_r <= '0;
        end else if (wr && addr == 8'(q)) begin
          en_r <= wdata[3:0];
          lb_r <= wdata[6:4];
        end
      end
      assign lane_en[4*q +: 4]  = en_r;
      assign loopback[3*q +: 3] = lb_r;
      assign ctrl_q[q]          = {lb_r, en_r};
    end else begin : g_off
      assign lane_en[4*q +: 4]  = '0;
      assign loopback[3*q +: 3] = '0;
      assign ctrl_q[q]          = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_srst <= '0;
      rx_srst <= '0;
    end else begin
      tx_srst <= (wr && addr == A_TXRST) ? wdata[N_QUADS-1:0] & QUAD_MASK : '0;
      rx_srst <= (wr && addr == A_RXRST) ? wdata[N_QUADS-1:0] & QUAD_MASK : '0;
    end
  end

  assign lane_st[0] = 64'(rx_rst_done & lane_mask);
  assign lane_st[1] = 64'(rx_fsm_done & lane_mask);
  assign lane_st[2] = 64'(rx_aligned  & lane_mask);
  assign lane_st[3] = 64'(rx_realign  & lane_mask);
  assign lane_st[4] = 64'(rx_disperr  & lane_mask);
  assign lane_st[5] = 64'(rx_encerr   & lane_mask);

  always_comb begin
    rd_mux = '0;
    for (int q = 0; q < N_QUADS; q++)
      if (addr == 8'(q)) rd_mux = 32'(ctrl_q[q]);
    case (addr)
      8'h12: rd_mux = 32'(pll_lock     & QUAD_MASK);
      8'h13: rd_mux = 32'(refclk_lost  & QUAD_MASK);
      8'h14: rd_mux = 32'(pll_rst_done & QUAD_MASK);
      8'h15: rd_mux = 32'(tx_rst_done  & QUAD_MASK);
      8'h16: rd_mux = 32'(tx_fsm_done  & QUAD_MASK);
      default: ;
    endcase
    for (int k = 0; k < 6; k++) begin
      if (addr == A_LANE0 + 8'(2*k))     rd_mux = lane_st[k][31:0];
      if (addr == A_LANE0 + 8'(2*k + 1)) rd_mux = lane_st[k][63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= wr | rd;
      rdata <= rd ? rd_mux : '0;
    end
  end

  assert_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (wr || rd) |=> ack);
  assert_no_spurious_ack_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr || rd) |=> !ack);
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(lane_en) && $stable(loopback)));
  assert_tx_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_srst != '0) |-> $past(wr && addr == A_TXRST));
  assert_rx_pulse_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_srst != '0) |-> $past(wr && addr == A_RXRST));
  assert_pulse_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !((tx_srst != '0) && (rx_srst != '0)));
endmodule

// File: tb/xcvr_regbank_test.sv
module xcvr_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam logic [NQ-1:0] M = 4'b1011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic ack;
  logic [4*NQ-1:0] lane_en;
  logic [3*NQ-1:0] loopback;
  logic [NQ-1:0] tx_srst, rx_srst;
  logic [NQ-1:0] pll_lock = '0, refclk_lost = '0, pll_rst_done = '0, tx_rst_done = '0, tx_fsm_done = '0;
  logic [4*NQ-1:0] rx_rst_done = '0, rx_fsm_done = '0, rx_aligned = '0, rx_realign = '0, rx_disperr = '0, rx_encerr = '0;

  int checks = 0, errors = 0;
  logic [6:0] m_ctrl [NQ];
  logic [15:0] lm;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_regbank #(.N_QUADS(NQ), .QUAD_MASK(M)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .ack(ack), .lane_en(lane_en), .loopback(loopback),
    .tx_srst(tx_srst), .rx_srst(rx_srst), .pll_lock(pll_lock),
    .refclk_lost(refclk_lost), .pll_rst_done(pll_rst_done),
    .tx_rst_done(tx_rst_done), .tx_fsm_done(tx_fsm_done),
    .rx_rst_done(rx_rst_done), .rx_fsm_done(rx_fsm_done),
    .rx_aligned(rx_aligned), .rx_realign(rx_realign),
    .rx_disperr(rx_disperr), .rx_encerr(rx_encerr));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    logic [15:0] src;
    if (a < NQ) return M[a] ? 32'(m_ctrl[a]) : 32'h0;
    case (a)
      'h12: return 32'(pll_lock & M);
      'h13: return 32'(refclk_lost & M);
      'h14: return 32'(pll_rst_done & M);
      'h15: return 32'(tx_rst_done & M);
      'h16: return 32'(tx_fsm_done & M);
      default: ;
    endcase
    if (a >= 'h18 && a <= 'h23) begin
      if ((a - 'h18) % 2 == 1) return 32'h0;
      case ((a - 'h18) / 2)
        0: src = rx_rst_done;
        1: src = rx_fsm_done;
        2: src = rx_aligned;
        3: src = rx_realign;
        4: src = rx_disperr;
        default: src = rx_encerr;
      endcase
      return 32'(src & lm);
    end
    return 32'h0;
  endfunction

  function automatic logic [15:0] exp_en();
    logic [15:0] v = '0;
    for (int q = 0; q < NQ; q++) v[4*q +: 4] = M[q] ? m_ctrl[q][3:0] : 4'h0;
    return v;
  endfunction

  function automatic logic [11:0] exp_lb();
    logic [11:0] v = '0;
    for (int q = 0; q < NQ; q++) v[3*q +: 3] = M[q] ? m_ctrl[q][6:4] : 3'h0;
    return v;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk(ack === 1'b1, req, 32'(ack), 32'h1);
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [31:0] e;
    e = exp_rd(int'(a));
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(ack === 1'b1, "R9 ack", 32'(ack), 32'h1);
    chk(rdata === e, req, rdata, e);
  endtask

  task automatic check_outputs(input string req);
    chk(lane_en === exp_en(), req, 32'(lane_en), 32'(exp_en()));
    chk(loopback === exp_lb(), req, 32'(loopback), 32'(exp_lb()));
  endtask

  task automatic set_status(input int t);
    logic [15:0] s;
    s = 16'(t * 16'h3A7 ^ 16'h5C1);
    pll_lock = s[3:0]; refclk_lost = s[7:4]; pll_rst_done = s[11:8];
    tx_rst_done = s[15:12]; tx_fsm_done = ~s[3:0];
    rx_rst_done = s; rx_fsm_done = ~s; rx_aligned = {s[7:0], s[15:8]};
    rx_realign = s ^ 16'hA5A5; rx_disperr = 16'(s * 3); rx_encerr = {s[0], s[15:1]};
  endtask

  task automatic sweep_all(input string req);
    for (int a = 0; a < 256; a++) begin
      string r;
      if (a >= 'h12 && a <= 'h14) r = {req, " R5"};
      else if (a == 'h15 || a == 'h16) r = {req, " R6"};
      else if (a >= 'h18 && a <= 'h23) r = {req, " R7"};
      else if (a < NQ) r = {req, " R2/R8"};
      else r = {req, " R9 unmapped or strobe"};
      do_read(8'(a), r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_ctrl[q] = '0;
      lm[4*q +: 4] = {4{M[q]}};
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_outputs("R1 reset outputs");
    chk(tx_srst === '0, "R1 tx pulse", 32'(tx_srst), 0);
    chk(rx_srst === '0, "R1 rx pulse", 32'(rx_srst), 0);
    for (int q = 0; q < NQ; q++) do_read(8'(q), "R1 ctrl reads 0");

    // R2 / R8 control sweep over every field value of every quad
    for (int q = 0; q < NQ; q++)
      for (int v = 0; v < 128; v++) begin
        do_write(8'(q), {25'h1ABCDEF, 7'(v)}, "R2 write ack");
        if (M[q]) m_ctrl[q] = 7'(v);
        check_outputs(M[q] ? "R2 ctrl outputs" : "R8 disabled quad outputs");
        do_read(8'(q), M[q] ? "R2 ctrl readback" : "R8 disabled quad reads 0");
      end
    for (int q = 0; q < NQ; q++) do_read(8'(q), "R2 hold after other writes");

    // R3 / R4 pulse sweep
    for (int d = 0; d < 16; d++) begin
      do_write(8'h10, 32'hFFFF_FFF0 | 32'(d), "R3 write ack");
      chk(tx_srst === (4'(d) & M), "R3 tx pulse", 32'(tx_srst), 32'(4'(d) & M));
      chk(rx_srst === '0, "R4 rx quiet on tx strobe", 32'(rx_srst), 0);
      @(negedge clk);
      chk(tx_srst === '0, "R3 one cycle", 32'(tx_srst), 0);
      do_read(8'h10, "R3 strobe reads 0");
      do_write(8'h11, 32'(d), "R4 write ack");
      chk(rx_srst === (4'(d) & M), "R4 rx pulse", 32'(rx_srst), 32'(4'(d) & M));
      chk(tx_srst === '0, "R4 tx quiet on rx strobe", 32'(tx_srst), 0);
      @(negedge clk);
      chk(rx_srst === '0, "R4 one cycle", 32'(rx_srst), 0);
      do_read(8'h11, "R4 strobe reads 0");
      check_outputs("R3 ctrl untouched by strobe");
    end

    // R5 R6 R7 R9 full address sweeps under several status patterns
    for (int t = 0; t < 3; t++) begin
      set_status(t);
      sweep_all("status");
    end

    // R10 writes to read-only space
    set_status(7);
    for (int a = 'h12; a < 256; a++) begin
      do_write(8'(a), 32'hFFFF_FFFF, "R10 write ack");
      chk(tx_srst === '0 && rx_srst === '0, "R10 no pulse", 32'({tx_srst, rx_srst}), 0);
    end
    check_outputs("R10 ctrl outputs unchanged");
    sweep_all("R10 after ro writes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule